// File: doc/BRIEF.md
# Real Address Conversion Unit

This unit forms the result word of a load-real-address operation. It takes the address field of an effective word as a 22-bit byte-resolution virtual address. It also takes a 2-bit size selector, carried in from the condition code before the operation. If the word address is 16 or more, the unit translates the address through an external page map. Lower addresses skip translation and are returned as they are. The selected address is shifted down to byte, halfword, word or doubleword resolution and right-aligned in a 32-bit result. Every bit above the address is cleared.

The page map lives outside the unit. The unit presents a virtual page number and takes back a real page number in the same cycle. A page is 512 words (2048 bytes), so the 11-bit byte offset passes straight through below the real page number. A memory-size input, counted in words, marks where real memory ends. A translated address at or beyond that limit raises a nonexistent-memory flag. The map-enable bit of the current status word is accepted on a pin and has no effect on the result.

Results are registered: each accepted request produces its output one clock later. The outputs keep their last value while no request is presented.

Top module: `real_addr_conv`

## Requirements
- R1: While rst_n is low, and after it rises until the first request, out_valid, out_result and out_nxm are all 0.
- R2: out_valid is 1 in the cycle after a cycle with in_valid high, and 0 otherwise. When in_valid is low, out_result and out_nxm keep their previous values.
- R3: size_sel selects the resolution with the encoding 00 = byte (22 bits), 01 = halfword (21 bits), 10 = word (20 bits), 11 = doubleword (19 bits). out_result equals the selected address shifted right by size_sel, with its least significant bit in out_result bit 0.
- R4: out_result bits 31 down to 22 are always 0. For sizes 01, 10 and 11, the top 1, 2 or 3 bits of the 22-bit field (bits 21, 21:20 or 21:19) are also 0.
- R5: When vaddr[21:2] >= 16, map_vpn = vaddr[21:11] and the real byte address is {map_rpn, vaddr[10:0]}.
- R6: When vaddr[21:2] < 16, the address used is vaddr itself, and map_rpn has no effect.
- R7: map_en has no effect on out_result or out_nxm.
- R8: For a translated address, out_nxm is 1 exactly when the real word address (real byte address bits 21:2) is >= mem_words. Equality counts as nonexistent.
- R9: For an untranslated address, out_nxm is 0 whatever mem_words holds, including 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| size_sel | input | 2 | Resolution selector (00 byte, 01 halfword, 10 word, 11 doubleword) |
| vaddr | input | 22 | Byte-resolution virtual address field |
| map_en | input | 1 | Status-word map-enable bit (no effect) |
| mem_words | input | 20 | Installed memory size in words |
| map_vpn | output | 11 | Virtual page number presented to the page map |
| map_rpn | input | 11 | Real page number returned by the page map |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 32 | Right-aligned real or untranslated address |
| out_nxm | output | 1 | Real address points at nonexistent memory |

## Verification
The bench builds the unit with its default widths: a 22-bit address, an 11-bit page offset, a threshold of 16 words and a 32-bit result. At these values the bench can drive the highest virtual page (0x7FF) and addresses on both sides of the word-15/word-16 boundary. It can also set the memory limit exactly equal to a real word address and one above it. A bench-side page map returns a scrambled page number, so a dropped or misplaced page field changes the result. Every size code is applied to both translated and untranslated addresses, and map_en is flipped while the other inputs are held.

// File: rtl/rac_pkg.sv
package rac_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } size_e;

  localparam int NUM_SIZES = 4;
endpackage

// File: rtl/rac_xlate.sv
module rac_xlate #(
  parameter int VA_W      = 22,
  parameter int OFF_W     = 11,
  parameter int LOW_LIMIT = 16
) (
  input  logic [VA_W-1:0]       vaddr,
  input  logic [VA_W-OFF_W-1:0] map_rpn,
  output logic [VA_W-OFF_W-1:0] map_vpn,
  output logic [VA_W-1:0]       real_addr,
  output logic                  mapped
);
  localparam int WSH  = 2;
  localparam int WA_W = VA_W - WSH;

  function automatic logic above_limit(input logic [WA_W-1:0] wa);
    return wa >= WA_W'(LOW_LIMIT);
  endfunction

  assign map_vpn   = vaddr[VA_W-1:OFF_W];
  assign mapped    = above_limit(vaddr[VA_W-1:WSH]);
  assign real_addr = mapped ? {map_rpn, vaddr[OFF_W-1:0]} : vaddr;
endmodule

// File: rtl/rac_align.sv
module rac_align
  import rac_pkg::*;
#(
  parameter int VA_W  = 22,
  parameter int RES_W = 32
) (
  input  logic [VA_W-1:0]  addr,
  input  size_e            size,
  output logic [RES_W-1:0] result
);
  logic [RES_W-1:0] cand [NUM_SIZES];

  function automatic logic [RES_W-1:0] widen(input logic [VA_W-1:0] a);
    return {{(RES_W-VA_W){1'b0}}, a};
  endfunction

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    assign cand[g] = widen(addr) >> g;
  end

  assign result = cand[size];
endmodule

// File: rtl/rac_nxm.sv
module rac_nxm #(
  parameter int WA_W = 20
) (
  input  logic [WA_W-1:0] real_word,
  input  logic            mapped,
  input  logic [WA_W-1:0] mem_words,
  output logic            nxm
);
  function automatic logic beyond(input logic [WA_W-1:0] w, input logic [WA_W-1:0] lim);
    return w >= lim;
  endfunction

  assign nxm = mapped && beyond(real_word, mem_words);
endmodule

// File: rtl/real_addr_conv.sv
module real_addr_conv
  import rac_pkg::*;
#(
  parameter int VA_W      = 22,
  parameter int OFF_W     = 11,
  parameter int LOW_LIMIT = 16,
  parameter int RES_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            size_sel,
  input  logic [VA_W-1:0]       vaddr,
  input  logic                  map_en,
  input  logic [VA_W-3:0]       mem_words,
  output logic [VA_W-OFF_W-1:0] map_vpn,
  input  logic [VA_W-OFF_W-1:0] map_rpn,
  output logic                  out_valid,
  output logic [RES_W-1:0]      out_result,
  output logic                  out_nxm
);
  localparam int WA_W = VA_W - 2;

  logic [VA_W-1:0]  real_addr;
  logic             mapped;
  logic [RES_W-1:0] aligned;
  logic             nxm_now;
  logic             unused_map_en;

  assign unused_map_en = map_en;

  rac_xlate #(.VA_W(VA_W), .OFF_W(OFF_W), .LOW_LIMIT(LOW_LIMIT)) u_xlate (
    .vaddr(vaddr), .map_rpn(map_rpn), .map_vpn(map_vpn),
    .real_addr(real_addr), .mapped(mapped)
  );

  rac_align #(.VA_W(VA_W), .RES_W(RES_W)) u_align (
    .addr(real_addr), .size(size_e'(size_sel)), .result(aligned)
  );

  rac_nxm #(.WA_W(WA_W)) u_nxm (
    .real_word(real_addr[VA_W-1:2]), .mapped(mapped),
    .mem_words(mem_words), .nxm(nxm_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_nxm    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= aligned;
        out_nxm    <= nxm_now;
      end
    end
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_nxm)));

  // R4
  high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_result >> (VA_W - int'($past(size_sel)))) == '0));

  // R9
  bypass_no_nxm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mapped) |=> !out_nxm);

  // R6
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mapped && size_sel == 2'b00) |=> (out_result[VA_W-1:0] == $past(vaddr)));
endmodule

// File: tb/test_real_addr_conv.sv
module test_real_addr_conv;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // vector: {size[1:0], vaddr[21:0], mem_words[19:0], map_en}
  localparam logic [44:0] VEC [NV] = '{
    {2'b00, 22'h000004, 20'h00000, 1'b0},
    {2'b11, 22'h00003F, 20'h00000, 1'b1},
    {2'b00, 22'h000040, 20'hFFFFF, 1'b0},
    {2'b01, 22'h3FFFFF, 20'hFFFFF, 1'b1},
    {2'b10, 22'h1234A7, 20'h00100, 1'b0},
    {2'b11, 22'h2A5F3C, 20'h80000, 1'b1},
    {2'b01, 22'h00003E, 20'h00000, 1'b0},
    {2'b10, 22'h000020, 20'h00001, 1'b1},
    {2'b00, 22'h3FF800, 20'h00002, 1'b0},
    {2'b11, 22'h0007FF, 20'hFFFFF, 1'b0}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [1:0] size_sel = 0;
  logic [21:0] vaddr = 0;
  logic map_en = 0;
  logic [19:0] mem_words = 0;
  logic [10:0] map_vpn, map_rpn;
  logic out_valid, out_nxm;
  logic [31:0] out_result;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [10:0] pmap(input logic [10:0] v);
    return 11'((int'(v) * 3 + 5) % 2048);
  endfunction
  assign map_rpn = pmap(map_vpn);

  real_addr_conv i_real_addr_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
    .vaddr(vaddr), .map_en(map_en), .mem_words(mem_words),
    .map_vpn(map_vpn), .map_rpn(map_rpn), .out_valid(out_valid),
    .out_result(out_result), .out_nxm(out_nxm)
  );

  function automatic longint model_real(input logic [21:0] va);
    longint a = longint'(va);
    if (a / 4 < 16) return a;
    return longint'(pmap(11'(a / 2048))) * 2048 + (a % 2048);
  endfunction

  function automatic longint model_res(input logic [21:0] va, input logic [1:0] s);
    return model_real(va) / (longint'(1) << s);
  endfunction

  function automatic bit model_nxm(input logic [21:0] va, input logic [19:0] mw);
    if (longint'(va) / 4 < 16) return 0;
    return (model_real(va) / 4) >= longint'(mw);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] s, input logic [21:0] va,
                       input logic [19:0] mw, input logic me);
    @(negedge clk);
    in_valid = 1; size_sel = s; vaddr = va; mem_words = mw; map_en = me;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    // R1 reset state, during and after reset
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", out_valid, 0);
    chk("R1 result in reset", out_result, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", out_valid, 0);
    chk("R1 nxm after reset", out_nxm, 0);
    chk("R1 result after reset", out_result, 0);

    // Table walk: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [1:0] s = VEC[i][44:43];
      logic [21:0] va = VEC[i][42:21];
      logic [19:0] mw = VEC[i][20:1];
      apply(s, va, mw, VEC[i][0]);
      chk("R2 valid", out_valid, 1);
      chk("R3 R5 R6 result", out_result, model_res(va, s));
      chk("R8 R9 nxm", out_nxm, model_nxm(va, mw));
      chk("R4 high bits", out_result >> (22 - s), 0);
    end

    // R5 page number presented to the map
    @(negedge clk); vaddr = 22'h2A5F3C;
    #1 chk("R5 map_vpn", map_vpn, 11'h54B);

    // R2 hold while idle
    apply(2'b00, 22'h1234A7, 20'h00100, 0);
    held = out_result;
    @(negedge clk); size_sel = 2'b11; vaddr = 22'h000008; mem_words = 0;
    @(negedge clk);
    chk("R2 valid low when idle", out_valid, 0);
    chk("R2 result held", out_result, held);
    chk("R2 nxm held", out_nxm, 1);

    // R8 boundary: limit equals real word address, then one above
    begin
      logic [21:0] va = 22'h155554;
      longint rw = model_real(va) / 4;
      apply(2'b10, va, 20'(rw), 0);
      chk("R8 nxm at equal limit", out_nxm, 1);
      apply(2'b10, va, 20'(rw + 1), 0);
      chk("R8 nxm one above limit", out_nxm, 0);
      apply(2'b10, va, 20'(rw - 1), 0);
      chk("R8 nxm below limit", out_nxm, 1);
    end

    // R6 R9 word 15 bypass vs word 16 translated, limit 0
    apply(2'b00, 22'h00003C, 20'h00000, 0);
    chk("R6 word15 untranslated", out_result, 32'h3C);
    chk("R9 no nxm with zero limit", out_nxm, 0);
    apply(2'b00, 22'h000040, 20'h00000, 0);
    chk("R5 word16 translated", out_result, model_res(22'h000040, 2'b00));
    chk("R8 word16 nxm zero limit", out_nxm, 1);

    // R7 map_en flip gives identical results
    apply(2'b01, 22'h2A5F3C, 20'h40000, 0);
    held = out_result;
    apply(2'b01, 22'h2A5F3C, 20'h40000, 1);
    chk("R7 map_en no effect result", out_result, held);
    chk("R7 map_en no effect value", out_result, model_res(22'h2A5F3C, 2'b01));

    // R3 each size on one translated address
    for (int s = 0; s < 4; s++) begin
      apply(2'(s), 22'h3FFFFF, 20'hFFFFF, 0);
      chk("R3 size sweep", out_result, model_res(22'h3FFFFF, 2'(s)));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule